// File: doc/BRIEF.md
# Waveform Parameter Controller

This block holds the user settings of a function generator and updates them from front-panel controls. It accepts single-cycle pulses from already debounced buttons (waveform select, amplitude, encoder push) and the raw two-phase signals of a rotary encoder. From these it keeps four settings:

- the waveform shape, with a matching colour indicator;
- an amplitude level in tenths of full scale;
- an output frequency in hertz;
- a decade exponent for the tuning step.

A synthesis core and a display driver elsewhere on the chip read these settings.

Turning the encoder moves the frequency up or down by the current step, and the result is clamped to a fixed range. Each press of the encoder shaft multiplies the step by ten and wraps back to 1 Hz after the largest decade. The encoder phases are resynchronised inside the block. Direction is taken from the level of phase B at the counting edge of phase A, so each full detent cycle gives exactly one count.

Top module: `wavegen_ctrl`

## Requirements
- R1: After reset the waveform code is 0 (sine), the indicator shows red, the amplitude level is 1, the frequency equals FREQ_INIT (default 1000 Hz) and the step exponent is 0.
- R2: A waveform pulse advances the code in the order 0 (sine), 1 (triangle), 2 (square), then back to 0, visible on the clock edge after the pulse. Code 3 never appears.
- R3: The indicator is one-hot, with bit 2 red for sine, bit 1 green for triangle and bit 0 blue for square (active high by default).
- R4: An amplitude pulse raises the level by 1, and a pulse at level 10 returns it to 1. Without a pulse the level holds.
- R5: An encoder-press pulse raises the step exponent by 1, and a press at STEP_EXP_MAX (default 7, a 10 MHz step) returns it to 0. The step applied to the frequency is 10 to the power of the exponent.
- R6: With the default rising-edge option, a rising edge of phase A while phase B is low counts clockwise and adds the step. The new frequency is visible by the third clock edge after the A transition.
- R7: A clockwise count never takes the frequency above FREQ_MAX (default 20,000,000 Hz). It saturates there.
- R8: A rising edge of phase A while phase B is high counts counter-clockwise and subtracts the step, saturating at 0 Hz.
- R9: A full quadrature cycle produces exactly one count. Edges of phase B and the falling edge of phase A leave the frequency unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_pulse | input | 1 | One-cycle pulse: next waveform |
| amp_pulse | input | 1 | One-cycle pulse: next amplitude level |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_press | input | 1 | One-cycle pulse: next step decade |
| wave_code | output | 2 | 0 sine, 1 triangle, 2 square |
| rgb_led | output | 3 | Colour indicator {red, green, blue} |
| amp_level | output | 4 | Amplitude in tenths of full scale, 1 to 10 |
| freq_hz | output | 25 | Output frequency in Hz |
| step_exp | output | 3 | Step decade exponent, 0 to 7 |

## Verification
The bench builds the block with its default parameters: a 25-bit frequency, a 20 MHz ceiling, a start value of 1000 Hz, seven step decades, two synchroniser stages and counting on the rising edge of A. With these values, seven encoder presses reach the 10 MHz step. Two or three clockwise detents then reach the ceiling and press against it, and a 1 kHz step subtracted from 1 kHz and again from 0 exercises the floor. One further press wraps the step back to 1 Hz, which a single detent then confirms.

// File: rtl/wgc_pkg.sv
package wgc_pkg;

   typedef enum logic [1:0] {
      WAVE_SINE   = 2'd0,
      WAVE_TRI    = 2'd1,
      WAVE_SQUARE = 2'd2
   } wave_e;

   function automatic wave_e wave_next(input wave_e cur);
      case (cur)
         WAVE_SINE: return WAVE_TRI;
         WAVE_TRI:  return WAVE_SQUARE;
         default:   return WAVE_SINE;
      endcase
   endfunction

   function automatic logic [2:0] wave_colour(input wave_e cur);
      case (cur)
         WAVE_SINE: return 3'b100;
         WAVE_TRI:  return 3'b010;
         default:   return 3'b001;
      endcase
   endfunction

endpackage

// File: rtl/wgc_quad_dec.sv
module wgc_quad_dec #(
   parameter int SYNC_STAGES   = 2,
   parameter bit COUNT_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enc_a,
   input  logic enc_b,
   output logic step_up,
   output logic step_dn
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wgc_quad_dec: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] a_sync;
   logic [SYNC_STAGES-1:0] b_sync;
   logic                   a_last;
   logic                   a_now;
   logic                   b_now;
   logic                   a_edge;
   logic                   dir_cw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_sync <= '0;
         b_sync <= '0;
         a_last <= 1'b0;
      end else begin
         a_sync <= {a_sync[SYNC_STAGES-2:0], enc_a};
         b_sync <= {b_sync[SYNC_STAGES-2:0], enc_b};
         a_last <= a_sync[SYNC_STAGES-1];
      end
   end

   assign a_now = a_sync[SYNC_STAGES-1];
   assign b_now = b_sync[SYNC_STAGES-1];

   generate
      if (COUNT_ON_RISE) begin : g_rise
         assign a_edge = a_now & ~a_last;
         assign dir_cw = ~b_now;
      end else begin : g_fall
         assign a_edge = ~a_now & a_last;
         assign dir_cw = b_now;
      end
   endgenerate

   assign step_up = a_edge & dir_cw;
   assign step_dn = a_edge & ~dir_cw;

endmodule

// File: rtl/wgc_wave_sel.sv
module wgc_wave_sel #(
   parameter bit LED_ACTIVE_LOW = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       advance,
   output logic [1:0] code,
   output logic [2:0] led
);
   import wgc_pkg::*;

   wave_e      cur;
   logic [2:0] colour;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cur <= WAVE_SINE;
      else if (advance) cur <= wave_next(cur);
   end

   assign colour = wave_colour(cur);
   assign code   = cur;

   generate
      if (LED_ACTIVE_LOW) begin : g_led_low
         assign led = ~colour;
      end else begin : g_led_high
         assign led = colour;
      end
   endgenerate

endmodule

// File: rtl/wgc_amp_step.sv
module wgc_amp_step #(
   parameter int AMP_W      = 4,
   parameter int AMP_LEVELS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [AMP_W-1:0] level
);

   localparam logic [AMP_W-1:0] LVL_MIN = AMP_W'(1);
   localparam logic [AMP_W-1:0] LVL_MAX = AMP_W'(AMP_LEVELS);

   generate
      if (AMP_LEVELS < 1 || AMP_LEVELS >= (1 << AMP_W)) begin : g_bad_amp
         $error("wgc_amp_step: AMP_LEVELS does not fit AMP_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    level <= LVL_MIN;
      else if (bump) level <= (level >= LVL_MAX) ? LVL_MIN : level + 1'b1;
   end

endmodule

// File: rtl/wgc_freq_tune.sv
module wgc_freq_tune #(
   parameter int FREQ_W       = 25,
   parameter int FREQ_MAX     = 20_000_000,
   parameter int FREQ_INIT    = 1000,
   parameter int STEP_EXP_MAX = 7,
   parameter int EXP_W        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_up,
   input  logic              step_dn,
   input  logic              decade,
   output logic [FREQ_W-1:0] freq,
   output logic [EXP_W-1:0]  exp_out
);

   localparam int SUM_W = FREQ_W + 1;
   localparam logic [SUM_W-1:0] LIM = SUM_W'(FREQ_MAX);

   function automatic longint pow10(input int e);
      longint v = 1;
      for (int i = 0; i < e; i++) v = v * 10;
      return v;
   endfunction

   localparam longint STEP_TOP = pow10(STEP_EXP_MAX);

   generate
      if (longint'(FREQ_MAX) >= (longint'(1) << FREQ_W)) begin : g_bad_max
         $error("wgc_freq_tune: FREQ_MAX does not fit FREQ_W");
      end
      if (STEP_TOP >= (longint'(1) << FREQ_W)) begin : g_bad_step
         $error("wgc_freq_tune: largest step does not fit FREQ_W");
      end
      if (FREQ_INIT > FREQ_MAX || FREQ_INIT < 0) begin : g_bad_init
         $error("wgc_freq_tune: FREQ_INIT outside range");
      end
      if (STEP_EXP_MAX >= (1 << EXP_W)) begin : g_bad_exp
         $error("wgc_freq_tune: STEP_EXP_MAX does not fit EXP_W");
      end
   endgenerate

   logic [FREQ_W-1:0] step_val;
   logic [EXP_W-1:0]  exp_q;
   logic [SUM_W-1:0]  sum_up;
   logic [FREQ_W-1:0] freq_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q    <= '0;
         step_val <= FREQ_W'(1);
      end else if (decade) begin
         if (exp_q == EXP_W'(STEP_EXP_MAX)) begin
            exp_q    <= '0;
            step_val <= FREQ_W'(1);
         end else begin
            exp_q    <= exp_q + 1'b1;
            step_val <= FREQ_W'(step_val * FREQ_W'(10));
         end
      end
   end

   assign sum_up = {1'b0, freq} + {1'b0, step_val};

   always_comb begin
      freq_nx = freq;
      if (step_up)
         freq_nx = (sum_up > LIM) ? FREQ_W'(FREQ_MAX) : sum_up[FREQ_W-1:0];
      else if (step_dn)
         freq_nx = (freq < step_val) ? '0 : freq - step_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) freq <= FREQ_W'(FREQ_INIT);
      else        freq <= freq_nx;
   end

   assign exp_out = exp_q;

endmodule

// File: rtl/wavegen_ctrl.sv
module wavegen_ctrl #(
   parameter int FREQ_W         = 25,
   parameter int FREQ_MAX       = 20_000_000,
   parameter int FREQ_INIT      = 1000,
   parameter int STEP_EXP_MAX   = 7,
   parameter int EXP_W          = 3,
   parameter int AMP_W          = 4,
   parameter int AMP_LEVELS     = 10,
   parameter int SYNC_STAGES    = 2,
   parameter bit COUNT_ON_RISE  = 1'b1,
   parameter bit LED_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wave_pulse,
   input  logic              amp_pulse,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              enc_press,
   output logic [1:0]        wave_code,
   output logic [2:0]        rgb_led,
   output logic [AMP_W-1:0]  amp_level,
   output logic [FREQ_W-1:0] freq_hz,
   output logic [EXP_W-1:0]  step_exp
);

   logic step_up;
   logic step_dn;

   wgc_quad_dec #(
      .SYNC_STAGES  (SYNC_STAGES),
      .COUNT_ON_RISE(COUNT_ON_RISE)
   ) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .enc_a  (enc_a),
      .enc_b  (enc_b),
      .step_up(step_up),
      .step_dn(step_dn)
   );

   wgc_wave_sel #(
      .LED_ACTIVE_LOW(LED_ACTIVE_LOW)
   ) u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(wave_pulse),
      .code   (wave_code),
      .led    (rgb_led)
   );

   wgc_amp_step #(
      .AMP_W     (AMP_W),
      .AMP_LEVELS(AMP_LEVELS)
   ) u_amp (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (amp_pulse),
      .level(amp_level)
   );

   wgc_freq_tune #(
      .FREQ_W      (FREQ_W),
      .FREQ_MAX    (FREQ_MAX),
      .FREQ_INIT   (FREQ_INIT),
      .STEP_EXP_MAX(STEP_EXP_MAX),
      .EXP_W       (EXP_W)
   ) u_freq (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_up(step_up),
      .step_dn(step_dn),
      .decade (enc_press),
      .freq   (freq_hz),
      .exp_out(step_exp)
   );

endmodule

// File: rtl/wavegen_ctrl_chk.sv
module wavegen_ctrl_chk #(
   parameter int FREQ_W         = 25,
   parameter int FREQ_MAX       = 20_000_000,
   parameter int STEP_EXP_MAX   = 7,
   parameter int EXP_W          = 3,
   parameter int AMP_W          = 4,
   parameter int AMP_LEVELS     = 10,
   parameter bit LED_ACTIVE_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wave_pulse,
   input logic              amp_pulse,
   input logic              enc_press,
   input logic [1:0]        wave_code,
   input logic [2:0]        rgb_led,
   input logic [AMP_W-1:0]  amp_level,
   input logic [FREQ_W-1:0] freq_hz,
   input logic [EXP_W-1:0]  step_exp
);

   logic [2:0] led_hi;
   assign led_hi = LED_ACTIVE_LOW ? ~rgb_led : rgb_led;

   // R2
   wave_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wave_pulse |=> wave_code == (($past(wave_code) == 2'd2) ? 2'd0 : $past(wave_code) + 2'd1));

   // R2
   wave_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wave_code != 2'd3);

   // R3
   led_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(led_hi) == 1);

   // R3
   led_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_code == 2'd0) |-> led_hi[2]);

   // R4
   amp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      amp_pulse |=> amp_level == (($past(amp_level) >= AMP_W'(AMP_LEVELS)) ? AMP_W'(1) : $past(amp_level) + AMP_W'(1)));

   // R4
   amp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !amp_pulse |=> $stable(amp_level));

   // R5
   step_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_press |=> step_exp == (($past(step_exp) == EXP_W'(STEP_EXP_MAX)) ? '0 : $past(step_exp) + EXP_W'(1)));

   // R7
   freq_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_hz <= FREQ_W'(FREQ_MAX));

endmodule

bind wavegen_ctrl wavegen_ctrl_chk #(
   .FREQ_W        (FREQ_W),
   .FREQ_MAX      (FREQ_MAX),
   .STEP_EXP_MAX  (STEP_EXP_MAX),
   .EXP_W         (EXP_W),
   .AMP_W         (AMP_W),
   .AMP_LEVELS    (AMP_LEVELS),
   .LED_ACTIVE_LOW(LED_ACTIVE_LOW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wave_pulse(wave_pulse),
   .amp_pulse (amp_pulse),
   .enc_press (enc_press),
   .wave_code (wave_code),
   .rgb_led   (rgb_led),
   .amp_level (amp_level),
   .freq_hz   (freq_hz),
   .step_exp  (step_exp)
);

// File: tb/sim_wavegen_ctrl.sv
`timescale 1ns/1ps
module sim_wavegen_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wave_pulse = 1'b0;
   logic        amp_pulse = 1'b0;
   logic        enc_a = 1'b0;
   logic        enc_b = 1'b0;
   logic        enc_press = 1'b0;
   logic [1:0]  wave_code;
   logic [2:0]  rgb_led;
   logic [3:0]  amp_level;
   logic [24:0] freq_hz;
   logic [2:0]  step_exp;

   int checks = 0;
   int fails  = 0;
   longint exp_f;

   always #2.5 clk = ~clk;

   wavegen_ctrl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wave_pulse(wave_pulse),
      .amp_pulse (amp_pulse),
      .enc_a     (enc_a),
      .enc_b     (enc_b),
      .enc_press (enc_press),
      .wave_code (wave_code),
      .rgb_led   (rgb_led),
      .amp_level (amp_level),
      .freq_hz   (freq_hz),
      .step_exp  (step_exp)
   );

   task automatic chk(input string req, input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_wave(); wave_pulse = 1'b1; wait_neg(1); wave_pulse = 1'b0; endtask
   task automatic pulse_amp();  amp_pulse  = 1'b1; wait_neg(1); amp_pulse  = 1'b0; endtask
   task automatic pulse_step(); enc_press  = 1'b1; wait_neg(1); enc_press  = 1'b0; endtask

   // one full detent; A leads B for clockwise
   task automatic detent(input bit cw);
      if (cw) begin
         enc_a = 1'b1; wait_neg(6);
         enc_b = 1'b1; wait_neg(6);
         enc_a = 1'b0; wait_neg(6);
         enc_b = 1'b0; wait_neg(6);
      end else begin
         enc_b = 1'b1; wait_neg(6);
         enc_a = 1'b1; wait_neg(6);
         enc_b = 1'b0; wait_neg(6);
         enc_a = 1'b0; wait_neg(6);
      end
   endtask

   task automatic t_reset();
      chk("R1 wave_code", wave_code, 0);
      chk("R1 rgb_led", rgb_led, 3'b100);
      chk("R1 amp_level", amp_level, 1);
      chk("R1 freq_hz", freq_hz, 1000);
      chk("R1 step_exp", step_exp, 0);
   endtask

   task automatic t_wave();
      pulse_wave();
      chk("R2 triangle", wave_code, 1);
      chk("R3 green", rgb_led, 3'b010);
      pulse_wave();
      chk("R2 square", wave_code, 2);
      chk("R3 blue", rgb_led, 3'b001);
      pulse_wave();
      chk("R2 back to sine", wave_code, 0);
      chk("R3 red", rgb_led, 3'b100);
   endtask

   task automatic t_amp();
      for (int i = 2; i <= 10; i++) begin
         pulse_amp();
         chk("R4 amp step", amp_level, i);
      end
      wait_neg(3);
      chk("R4 amp hold", amp_level, 10);
      pulse_amp();
      chk("R4 amp wrap", amp_level, 1);
   endtask

   task automatic t_encoder_basic();
      // R6: count lands by the third edge after A rises
      enc_a = 1'b1; wait_neg(2);
      chk("R6 no early count", freq_hz, 1000);
      wait_neg(1);
      chk("R6 cw count latency", freq_hz, 1001);
      wait_neg(3);
      enc_b = 1'b1; wait_neg(6);
      enc_a = 1'b0; wait_neg(6);
      enc_b = 1'b0; wait_neg(6);
      chk("R9 one count per detent cw", freq_hz, 1001);
      detent(1'b0);
      chk("R8 ccw subtract", freq_hz, 1000);
      // R9: only B toggles, no count
      enc_b = 1'b1; wait_neg(6);
      enc_b = 1'b0; wait_neg(6);
      chk("R9 B edges ignored", freq_hz, 1000);
   endtask

   task automatic t_step_and_limits();
      for (int i = 1; i <= 3; i++) begin
         pulse_step();
         chk("R5 step exponent", step_exp, i);
      end
      detent(1'b0);
      chk("R8 subtract 1000", freq_hz, 0);
      detent(1'b0);
      chk("R8 floor at zero", freq_hz, 0);
      for (int i = 4; i <= 7; i++) pulse_step();
      chk("R5 top exponent", step_exp, 7);
      exp_f = 0;
      for (int i = 0; i < 3; i++) begin
         detent(1'b1);
         exp_f = (exp_f + 10_000_000 > 20_000_000) ? 20_000_000 : exp_f + 10_000_000;
         chk("R7 cw with 10 MHz step", freq_hz, exp_f);
      end
      chk("R7 ceiling", freq_hz, 20_000_000);
      detent(1'b0);
      chk("R8 ccw 10 MHz step", freq_hz, 10_000_000);
      pulse_step();
      chk("R5 exponent wrap", step_exp, 0);
      detent(1'b1);
      chk("R5 step back to 1 Hz", freq_hz, 10_000_001);
   endtask

   initial begin : watchdog
      #800000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(2);
      t_reset();
      t_wave();
      t_amp();
      t_encoder_basic();
      t_step_and_limits();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule